// File: doc/BRIEF.md
# Boost Converter Startup and Fault Sequencer

This block is the digital mode controller that brings a synchronous boost converter from power-off to regulation and recovers it after a failure. It reads synchronous comparator flags from the analog section. From them it steps through shutdown, two linear precharge phases with escalating current, a reference-ramped soft-start, and either boost regulation or pass-through bypass. Several distinct failure conditions lead to a fault state, which restarts the whole sequence on its own after a fixed wait.

All timeouts are counted in pulses of a one-microsecond `tick` input, and each limit is a parameter. A single shared counter serves every state and is cleared whenever the state changes. The outputs are a one-hot mode code, a precharge current selector, a reference-step enable, a switching enable and a one-cycle strobe that marks the end of soft-start.

Top module: `boost_start_seq`

## Requirements
- R1: After reset, and one cycle after `enable` is sampled low in any state, `modeOut` is 7'b0000001 (shutdown) and `preSel`, `ssStepEn`, `swEn` and `ssDone` are all 0. The one-hot mode bits are: bit0 shutdown, bit1 precharge-1, bit2 precharge-2, bit3 soft-start, bit4 boost, bit5 bypass, bit6 fault.
- R2: In shutdown, `enable` and `uvloOk` both high move the block to precharge-1 with `preSel`=2'b01 (lower current). With `uvloOk` low it stays in shutdown.
- R3: Precharge-1 goes to soft-start when `outNearIn` is high. Otherwise, on the PRE1_TICKS-th tick after entry (default 512), it goes to precharge-2 with `preSel`=2'b10 (higher current).
- R4: Precharge-2 goes to soft-start when `outNearIn` is high. Otherwise, on the PRE2_TICKS-th tick after entry (default 1024), it goes to fault.
- R5: Soft-start drives `ssStepEn`=1 and `swEn`=1. It leaves only when `rampDone` and `outAtTarget` are both high: to bypass if `inAboveTarget` is high, else to boost. On the SS_TICKS-th tick after entry (default 64) without that exit, it goes to fault.
- R6: `ssDone` is high for exactly one cycle, the first cycle of boost or bypass entered from soft-start. It is not raised on a bypass-to-boost move.
- R7: Boost drives `swEn`=1. `valleyLim` sampled high on ILIM_TICKS consecutive ticks (default 2000) moves it to fault. A cycle with `valleyLim` low restarts that count.
- R8: Bypass drives `swEn`=0. `bypDrop` high moves it to fault. `inAboveTarget` low moves it to boost.
- R9: `uvloOk` low while `enable` is high forces fault from precharge-1, precharge-2, soft-start, boost or bypass.
- R10: Fault drives `swEn`, `ssStepEn` and `preSel` to 0. On the RETRY_TICKS-th tick after entry (default 20000) it moves to precharge-1.
- R11: Timers advance only on cycles with `tick` high and restart from zero at every state entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle timing pulse, nominally 1 µs |
| enable | input | 1 | Converter enable |
| uvloOk | input | 1 | Input supply above lockout threshold |
| outNearIn | input | 1 | Output within precharge margin of input |
| outAtTarget | input | 1 | Output at regulation target |
| rampDone | input | 1 | Reference ramp has finished stepping |
| valleyLim | input | 1 | Valley current limit active |
| bypDrop | input | 1 | Input-to-output drop in bypass excessive |
| inAboveTarget | input | 1 | Input above output target |
| modeOut | output | 7 | One-hot mode code (bit map in R1) |
| preSel | output | 2 | Precharge current select: 01 lower, 10 higher |
| ssStepEn | output | 1 | Enables reference stepping |
| swEn | output | 1 | Enables converter switching |
| ssDone | output | 1 | One-cycle end-of-soft-start strobe |

## Verification
The assertions take every comparator flag and `tick` to be synchronous to `clk` and already free of glitches, and they take the state register to change only at clock edges. They do not model the analog loop. For example, they accept `outAtTarget` high while the block is still in precharge. The stimulus changes inputs only on falling edges and holds `tick` high except in one window where it is held low to freeze the timers. It keeps the flag combinations to those each requirement names, so every expected mode follows directly from the requirement table.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;
  localparam int NUM_MODES = 7;

  typedef enum logic [2:0] {
    ST_OFF = 3'd0, ST_PRE1 = 3'd1, ST_PRE2 = 3'd2, ST_SOFT = 3'd3,
    ST_BOOST = 3'd4, ST_BYPASS = 3'd5, ST_FAULT = 3'd6
  } seqState_e;

  typedef enum logic [2:0] {
    T_NONE, T_PRE1, T_PRE2, T_SOFT, T_ILIM, T_RETRY
  } tmrSel_e;

  typedef struct packed {
    logic    clr;
    logic    run;
    tmrSel_e sel;
  } tmrCmd_t;
endpackage

// File: rtl/boost_seq_timer.sv
module boost_seq_timer
  import boost_seq_pkg::*;
#(
  parameter int unsigned PRE1_TICKS  = 512,
  parameter int unsigned PRE2_TICKS  = 1024,
  parameter int unsigned SS_TICKS    = 64,
  parameter int unsigned ILIM_TICKS  = 2000,
  parameter int unsigned RETRY_TICKS = 20000
) (
  input  logic    clk,
  input  logic    rstN,
  input  tmrCmd_t cmd,
  output logic    timeUp
);
  localparam int unsigned MAX_A = (PRE1_TICKS > PRE2_TICKS) ? PRE1_TICKS : PRE2_TICKS;
  localparam int unsigned MAX_B = (SS_TICKS > ILIM_TICKS) ? SS_TICKS : ILIM_TICKS;
  localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_T = (MAX_C > RETRY_TICKS) ? MAX_C : RETRY_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic             hasLim;

  always_comb begin
    hasLim = 1'b1;
    unique case (cmd.sel)
      T_PRE1:  lim = CNT_W'(PRE1_TICKS - 1);
      T_PRE2:  lim = CNT_W'(PRE2_TICKS - 1);
      T_SOFT:  lim = CNT_W'(SS_TICKS - 1);
      T_ILIM:  lim = CNT_W'(ILIM_TICKS - 1);
      T_RETRY: lim = CNT_W'(RETRY_TICKS - 1);
      default: begin lim = '0; hasLim = 1'b0; end
    endcase
  end

  assign timeUp = hasLim && cmd.run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clr) cnt <= '0;
    else if (cmd.run)     cnt <= cnt + 1'b1;
  end

  // R11: without a tick or a clear the count holds
  p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.run && !cmd.clr) |=> $stable(cnt));
  // R11: a clear always restarts from zero
  p_clear_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clr |=> (cnt == '0));
endmodule

// File: rtl/boost_seq_ctrl.sv
module boost_seq_ctrl
  import boost_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 enable,
  input  logic                 uvloOk,
  input  logic                 outNearIn,
  input  logic                 outAtTarget,
  input  logic                 rampDone,
  input  logic                 valleyLim,
  input  logic                 bypDrop,
  input  logic                 inAboveTarget,
  input  logic                 timeUp,
  output tmrCmd_t              cmd,
  output logic [NUM_MODES-1:0] modeOut,
  output logic [1:0]           preSel,
  output logic                 ssStepEn,
  output logic                 swEn,
  output logic                 ssDone
);
  seqState_e state, nextState;
  logic      doneQ;
  logic      activeSt;

  assign activeSt = (state == ST_PRE1) || (state == ST_PRE2) || (state == ST_SOFT) ||
                    (state == ST_BOOST) || (state == ST_BYPASS);

  always_comb begin
    nextState = state;
    if (!enable) nextState = ST_OFF;
    else if (activeSt && !uvloOk) nextState = ST_FAULT;
    else begin
      unique case (state)
        ST_OFF:    if (uvloOk) nextState = ST_PRE1;
        ST_PRE1:   if (outNearIn) nextState = ST_SOFT;
                   else if (timeUp) nextState = ST_PRE2;
        ST_PRE2:   if (outNearIn) nextState = ST_SOFT;
                   else if (timeUp) nextState = ST_FAULT;
        ST_SOFT:   if (rampDone && outAtTarget)
                     nextState = inAboveTarget ? ST_BYPASS : ST_BOOST;
                   else if (timeUp) nextState = ST_FAULT;
        ST_BOOST:  if (valleyLim && timeUp) nextState = ST_FAULT;
        ST_BYPASS: if (bypDrop) nextState = ST_FAULT;
                   else if (!inAboveTarget) nextState = ST_BOOST;
        ST_FAULT:  if (timeUp) nextState = ST_PRE1;
        default:   nextState = ST_OFF;
      endcase
    end
  end

  always_comb begin
    cmd.run = tick;
    cmd.clr = (nextState != state) || (state == ST_OFF) ||
              ((state == ST_BOOST) && !valleyLim);
    unique case (state)
      ST_PRE1:  cmd.sel = T_PRE1;
      ST_PRE2:  cmd.sel = T_PRE2;
      ST_SOFT:  cmd.sel = T_SOFT;
      ST_BOOST: cmd.sel = T_ILIM;
      ST_FAULT: cmd.sel = T_RETRY;
      default:  cmd.sel = T_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_OFF;
      doneQ <= 1'b0;
    end else begin
      state <= nextState;
      doneQ <= (state == ST_SOFT) && ((nextState == ST_BOOST) || (nextState == ST_BYPASS));
    end
  end

  assign modeOut  = NUM_MODES'(1) << state;
  assign preSel   = {state == ST_PRE2, state == ST_PRE1};
  assign ssStepEn = (state == ST_SOFT);
  assign swEn     = (state == ST_SOFT) || (state == ST_BOOST);
  assign ssDone   = doneQ;

  // R1: enable low always lands in shutdown with switching off
  p_enable_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == ST_OFF) && !swEn && (preSel == 2'b00));
  // R9: lost supply in an active mode forces the fault state
  p_uvlo_fault_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !uvloOk && activeSt) |=> (state == ST_FAULT));
  // R6: end-of-soft-start strobe lasts one cycle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    ssDone |=> !ssDone);
  // R10: retry timer expiry restarts precharge
  p_retry_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FAULT && enable && timeUp) |=> (state == ST_PRE1));
  // R8: a bypass drop leads to fault
  p_byp_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BYPASS && enable && uvloOk && bypDrop) |=> (state == ST_FAULT));
endmodule

// File: rtl/boost_start_seq.sv
module boost_start_seq
  import boost_seq_pkg::*;
#(
  parameter int unsigned PRE1_TICKS  = 512,
  parameter int unsigned PRE2_TICKS  = 1024,
  parameter int unsigned SS_TICKS    = 64,
  parameter int unsigned ILIM_TICKS  = 2000,
  parameter int unsigned RETRY_TICKS = 20000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       enable,
  input  logic       uvloOk,
  input  logic       outNearIn,
  input  logic       outAtTarget,
  input  logic       rampDone,
  input  logic       valleyLim,
  input  logic       bypDrop,
  input  logic       inAboveTarget,
  output logic [6:0] modeOut,
  output logic [1:0] preSel,
  output logic       ssStepEn,
  output logic       swEn,
  output logic       ssDone
);
  tmrCmd_t tmrCmd;
  logic    timeUp;

  boost_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable), .uvloOk(uvloOk),
    .outNearIn(outNearIn), .outAtTarget(outAtTarget), .rampDone(rampDone),
    .valleyLim(valleyLim), .bypDrop(bypDrop), .inAboveTarget(inAboveTarget),
    .timeUp(timeUp), .cmd(tmrCmd), .modeOut(modeOut), .preSel(preSel),
    .ssStepEn(ssStepEn), .swEn(swEn), .ssDone(ssDone)
  );

  boost_seq_timer #(
    .PRE1_TICKS(PRE1_TICKS), .PRE2_TICKS(PRE2_TICKS), .SS_TICKS(SS_TICKS),
    .ILIM_TICKS(ILIM_TICKS), .RETRY_TICKS(RETRY_TICKS)
  ) u_timer (
    .clk(clk), .rstN(rstN), .cmd(tmrCmd), .timeUp(timeUp)
  );
endmodule

// File: tb/boost_start_seq_bench.sv
module boost_start_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic enable = 1'b0, uvloOk = 1'b0, outNearIn = 1'b0, outAtTarget = 1'b0;
  logic rampDone = 1'b0, valleyLim = 1'b0, bypDrop = 1'b0, inAboveTarget = 1'b0;
  logic [6:0] modeOut;
  logic [1:0] preSel;
  logic ssStepEn, swEn, ssDone;

  always #2.5 clk = ~clk;

  boost_start_seq u_boost_start_seq (
    .clk(clk), .rstN(rstN), .tick(tick), .enable(enable), .uvloOk(uvloOk),
    .outNearIn(outNearIn), .outAtTarget(outAtTarget), .rampDone(rampDone),
    .valleyLim(valleyLim), .bypDrop(bypDrop), .inAboveTarget(inAboveTarget),
    .modeOut(modeOut), .preSel(preSel), .ssStepEn(ssStepEn), .swEn(swEn),
    .ssDone(ssDone)
  );

  localparam int M_OFF = 0, M_PRE1 = 1, M_PRE2 = 2, M_SOFT = 3,
                 M_BOOST = 4, M_BYP = 5, M_FAULT = 6;

  typedef struct {
    int         when;
    logic [11:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares queued expectations at the falling edge they target
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].when == cyc) begin
      item_t it;
      logic [11:0] act;
      it = q.pop_front();
      act = {modeOut, preSel, ssStepEn, swEn, ssDone};
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s: actual %b expected %b (mode,pre,ss,sw,done)", it.req, act, it.exp);
      end
    end
  end

  // driver side: expectation for the falling edge after the next rising edge
  task automatic expectNext(int m, logic [1:0] pre, logic ss, logic sw, logic dn, string req);
    item_t it;
    it.when = cyc + 1;
    it.exp  = {7'(1) << m, pre, ss, sw, dn};
    it.req  = req;
    q.push_back(it);
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // called on the falling edge just after a state entry with tick held high
  task automatic holdThen(int n, int m0, logic [1:0] p0, logic s0, logic w0,
                          int m1, logic [1:0] p1, logic s1, logic w1, string req);
    waitCyc(n - 2);
    expectNext(m0, p0, s0, w0, 1'b0, req);
    waitCyc(1);
    expectNext(m1, p1, s1, w1, 1'b0, req);
    waitCyc(1);
  endtask

  task automatic toSoft();
    enable = 1; uvloOk = 1;
    expectNext(M_PRE1, 2'b01, 0, 0, 0, "R2");
    waitCyc(1);
    outNearIn = 1;
    expectNext(M_SOFT, 2'b00, 1, 1, 0, "R3");
    waitCyc(1);
    outNearIn = 0;
  endtask

  task automatic clearFlags();
    outNearIn = 0; outAtTarget = 0; rampDone = 0; valleyLim = 0;
    bypDrop = 0; inAboveTarget = 0;
  endtask

  initial begin
    waitCyc(1);
    expectNext(M_OFF, 2'b00, 0, 0, 0, "R1 reset");
    waitCyc(2);
    rstN = 1;
    // R2: enable without supply stays off
    enable = 1;
    expectNext(M_OFF, 2'b00, 0, 0, 0, "R2 no uvlo");
    waitCyc(1);
    uvloOk = 1;
    expectNext(M_PRE1, 2'b01, 0, 0, 0, "R2 enter pre1");
    waitCyc(1);
    // R11: no ticks, no timeout
    tick = 0;
    waitCyc(598);
    expectNext(M_PRE1, 2'b01, 0, 0, 0, "R11 frozen");
    waitCyc(1);
    tick = 1;
    outNearIn = 1;
    expectNext(M_SOFT, 2'b00, 1, 1, 0, "R3 near");
    waitCyc(1);
    outNearIn = 0;
    // R5: target without ramp done stays in soft-start
    outAtTarget = 1;
    expectNext(M_SOFT, 2'b00, 1, 1, 0, "R5 need ramp");
    waitCyc(1);
    rampDone = 1;
    expectNext(M_BOOST, 2'b00, 0, 1, 1, "R6 strobe boost");
    waitCyc(1);
    expectNext(M_BOOST, 2'b00, 0, 1, 0, "R6 strobe ends");
    waitCyc(1);
    // R7: limit broken one tick short, then held long enough
    valleyLim = 1;
    waitCyc(1998);
    expectNext(M_BOOST, 2'b00, 0, 1, 0, "R7 short");
    waitCyc(1);
    valleyLim = 0;
    expectNext(M_BOOST, 2'b00, 0, 1, 0, "R7 restart");
    waitCyc(1);
    valleyLim = 1;
    waitCyc(1998);
    expectNext(M_BOOST, 2'b00, 0, 1, 0, "R7 almost");
    waitCyc(1);
    expectNext(M_FAULT, 2'b00, 0, 0, 0, "R7 fault");
    waitCyc(1);
    clearFlags();
    // R10: retry wait then precharge-1
    holdThen(20000, M_FAULT, 2'b00, 0, 0, M_PRE1, 2'b01, 0, 0, "R10");
    // R3 / R4: precharge timeouts
    holdThen(512, M_PRE1, 2'b01, 0, 0, M_PRE2, 2'b10, 0, 0, "R3 timeout");
    holdThen(1024, M_PRE2, 2'b10, 0, 0, M_FAULT, 2'b00, 0, 0, "R4 timeout");
    // R1: enable low in fault
    enable = 0;
    expectNext(M_OFF, 2'b00, 0, 0, 0, "R1 from fault");
    waitCyc(1);
    // R1: enable low in precharge
    enable = 1;
    waitCyc(1);
    enable = 0;
    expectNext(M_OFF, 2'b00, 0, 0, 0, "R1 from pre1");
    waitCyc(1);
    // R5: soft-start timeout
    toSoft();
    holdThen(64, M_SOFT, 2'b00, 1, 1, M_FAULT, 2'b00, 0, 0, "R5 timeout");
    enable = 0;
    waitCyc(1);
    // R8: bypass entry and exit to boost
    toSoft();
    inAboveTarget = 1; outAtTarget = 1; rampDone = 1;
    expectNext(M_BYP, 2'b00, 0, 0, 1, "R8 bypass entry");
    waitCyc(1);
    expectNext(M_BYP, 2'b00, 0, 0, 0, "R6 strobe ends");
    waitCyc(1);
    inAboveTarget = 0;
    expectNext(M_BOOST, 2'b00, 0, 1, 0, "R8 exit no strobe");
    waitCyc(1);
    // R9: supply loss in boost
    uvloOk = 0;
    expectNext(M_FAULT, 2'b00, 0, 0, 0, "R9 uvlo");
    waitCyc(1);
    enable = 0; clearFlags();
    waitCyc(1);
    // R8: bypass drop
    toSoft();
    inAboveTarget = 1; outAtTarget = 1; rampDone = 1;
    waitCyc(1);
    bypDrop = 1;
    expectNext(M_FAULT, 2'b00, 0, 0, 0, "R8 drop");
    waitCyc(1);
    // R9: supply loss in precharge
    clearFlags(); enable = 0;
    waitCyc(1);
    enable = 1;
    waitCyc(1);
    uvloOk = 0;
    expectNext(M_FAULT, 2'b00, 0, 0, 0, "R9 pre1");
    waitCyc(2);
    done = 1;
  end

  initial begin
    int w = 0;
    while (!done && w < 150000) begin
      @(negedge clk);
      w++;
    end
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule